// File: doc/BRIEF.md
# Overclock Watchdog with Safe-Frequency Fallback

This block guards a clock generator against a system that hangs after its frequency has been raised. Once software sets the enable bit, the block counts down a programmed number of seconds, timed from a 1 ms tick that is made elsewhere. Every register write that reaches the block while it is enabled restarts the count. If the count runs out, the block makes three changes at once. It asserts a frequency override select together with a safe frequency code that was captured at that moment. It sets a sticky status flag. It drives an active-low reset pulse of fixed length onto an open-drain line.

The override holds until software writes a new frequency selection or clears the enable bit. The status flag holds until software clears it or clears the enable bit. After a timeout the countdown stops, and it starts again only when the block is re-armed. The reset pulse always runs to its full length, even if software changes the enable bit while the pulse is active.

Top module: `freq_wdog`

## Requirements
- R1: After reset, rst_od_no is 1 (line released), status_o is 0, ovr_sel_o is 0 and ovr_code_o is 0.
- R2: At a timeout, ovr_sel_o becomes 1 and ovr_code_o takes the value of safe_code_i sampled at that edge. While ovr_sel_o is 0, ovr_code_o reads 0.
- R3: While enabled, a timeout happens at the clock edge that samples the (secs × TICKS_PER_SEC)-th tick after the arming edge. The arming edge is the first edge that samples enable high, or the most recent kick. status_o, ovr_sel_o and rst_od_no all change at that edge.
- R4: rst_od_no is 0 (line pulled low) from the timeout edge until the edge that samples the PULSE_TICKS-th tick after it (default 288 ticks of 1 ms). At that edge it returns to 1.
- R5: A programmed timeout of 0 seconds behaves as 1 second.
- R6: An edge that samples en_i low clears status_o and ovr_sel_o, and stops the countdown. No timeout occurs while the block is disabled. A reset pulse already in progress still runs to its full width.
- R7: A reg_wr_i strobe while enabled restarts the countdown from that edge. If the kick falls on the same edge as the terminal tick, the kick wins and no timeout occurs.
- R8: status_o stays 1 after the pulse ends. status_clr_i clears it but leaves ovr_sel_o unchanged.
- R9: freq_wr_i clears ovr_sel_o and ovr_code_o but leaves status_o unchanged.
- R10: After a timeout the countdown halts. No further timeout occurs until the block is re-armed by a kick or by re-enabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 ms timebase strobe, one clock wide |
| en_i | input | 1 | Watchdog enable bit |
| secs_i | input | SEC_W | Timeout in whole seconds |
| safe_code_i | input | CODE_W | Safe frequency code applied on timeout |
| reg_wr_i | input | 1 | Any accepted register write (kick) |
| freq_wr_i | input | 1 | Write of the frequency selection |
| status_clr_i | input | 1 | Write that clears the status bit |
| rst_od_no | output | 1 | Open-drain reset: 0 = pull low, 1 = release |
| status_o | output | 1 | Sticky timeout flag |
| ovr_sel_o | output | 1 | Frequency override active |
| ovr_code_o | output | CODE_W | Override frequency code |

## Verification
The bench provokes two cases where functions meet in the same clock edge.

- **Kick on the terminal tick.** A register write is timed to land on exactly the terminal tick. This is done by waiting for the tick just before the final one while tick_i is already high. The bench then expects no pulse at that edge and a fresh full-length countdown measured from it.
- **Disable during a pulse.** The enable bit is dropped while a reset pulse is running. The bench checks that status and override clear on the next edge while the line stays low. The scoreboard then expects the release at the original 288-tick position.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    CD_IDLE = 2'd0,
    CD_RUN  = 2'd1,
    CD_EXP  = 2'd2
  } cd_state_e;
endpackage

// File: rtl/fwd_sec_timer.sv
module fwd_sec_timer
  import fwd_pkg::*;
#(
  parameter int TPS   = 1000,
  parameter int SEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             kick_i,
  input  logic             tick_i,
  input  logic [SEC_W-1:0] secs_i,
  output logic             fire_o
);
  localparam int MS_W = $clog2(TPS);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(TPS - 1);
  localparam logic [SEC_W-1:0] SEC_ONE = SEC_W'(1);

  cd_state_e        state_q, state_d;
  logic [MS_W-1:0]  ms_q, ms_d;
  logic [SEC_W-1:0] sec_q, sec_d, load;
  logic             terminal;

  // zero seconds is treated as one
  assign load     = (secs_i == '0) ? SEC_ONE : secs_i;
  assign terminal = tick_i && (ms_q == MS_LAST) && (sec_q == SEC_ONE);
  assign fire_o   = en_i && !kick_i && (state_q == CD_RUN) && terminal;

  always_comb begin
    state_d = state_q;
    ms_d    = ms_q;
    sec_d   = sec_q;
    if (!en_i) begin
      state_d = CD_IDLE;
      ms_d    = '0;
      sec_d   = '0;
    end else if (kick_i || state_q == CD_IDLE) begin
      state_d = CD_RUN;
      ms_d    = '0;
      sec_d   = load;
    end else if (state_q == CD_RUN && tick_i) begin
      if (ms_q == MS_LAST) begin
        ms_d = '0;
        if (sec_q == SEC_ONE) state_d = CD_EXP;
        else                  sec_d   = sec_q - SEC_ONE;
      end else begin
        ms_d = ms_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CD_IDLE;
      ms_q    <= '0;
      sec_q   <= '0;
    end else begin
      state_q <= state_d;
      ms_q    <= ms_d;
      sec_q   <= sec_d;
    end
  end

  p_run_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == CD_RUN |-> sec_q != '0);
  p_kick_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && kick_i) |=> (state_q == CD_RUN && ms_q == '0));
  p_halt_after_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CD_EXP && en_i && !kick_i) |=> state_q == CD_EXP);
  p_ms_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms_q <= MS_LAST);
endmodule

// File: rtl/fwd_rst_pulse.sv
module fwd_rst_pulse #(
  parameter int PULSE = 288
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic tick_i,
  output logic low_o
);
  localparam int CNT_W = $clog2(PULSE + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PULSE);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (fire_i) begin
      active_q <= 1'b1;
      cnt_q    <= CNT_FULL;
    end else if (active_q && tick_i) begin
      if (cnt_q == CNT_ONE) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q - CNT_ONE;
      end
    end
  end

  assign low_o = active_q;

  p_cnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q != '0 && cnt_q <= CNT_FULL));
  p_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> ($past(cnt_q) == CNT_ONE && $past(tick_i)));
endmodule

// File: rtl/fwd_override.sv
module fwd_override #(
  parameter int CODE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              en_i,
  input  logic              freq_wr_i,
  input  logic              status_clr_i,
  input  logic [CODE_W-1:0] safe_code_i,
  output logic              status_o,
  output logic              ovr_sel_o,
  output logic [CODE_W-1:0] ovr_code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= 1'b0;
    end else if (fire_i) begin
      status_o <= 1'b1;
    end else if (!en_i || status_clr_i) begin
      status_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_sel_o  <= 1'b0;
      ovr_code_o <= '0;
    end else if (fire_i) begin
      ovr_sel_o  <= 1'b1;
      ovr_code_o <= safe_code_i;
    end else if (!en_i || freq_wr_i) begin
      ovr_sel_o  <= 1'b0;
      ovr_code_o <= '0;
    end
  end

  p_code_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_sel_o) |-> ovr_code_o == $past(safe_code_i));
  p_disable_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!status_o && !ovr_sel_o));
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && en_i && !status_clr_i) |=> status_o);
endmodule

// File: rtl/freq_wdog.sv
module freq_wdog #(
  parameter int TICKS_PER_SEC = 1000,
  parameter int PULSE_TICKS   = 288,
  parameter int SEC_W         = 8,
  parameter int CODE_W        = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic [SEC_W-1:0]  secs_i,
  input  logic [CODE_W-1:0] safe_code_i,
  input  logic              reg_wr_i,
  input  logic              freq_wr_i,
  input  logic              status_clr_i,
  output logic              rst_od_no,
  output logic              status_o,
  output logic              ovr_sel_o,
  output logic [CODE_W-1:0] ovr_code_o
);
  logic fire;
  logic pulse_low;

  fwd_sec_timer #(.TPS(TICKS_PER_SEC), .SEC_W(SEC_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .kick_i (reg_wr_i),
    .tick_i (tick_i),
    .secs_i (secs_i),
    .fire_o (fire)
  );

  fwd_rst_pulse #(.PULSE(PULSE_TICKS)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .tick_i (tick_i),
    .low_o  (pulse_low)
  );

  fwd_override #(.CODE_W(CODE_W)) u_ovr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fire_i       (fire),
    .en_i         (en_i),
    .freq_wr_i    (freq_wr_i),
    .status_clr_i (status_clr_i),
    .safe_code_i  (safe_code_i),
    .status_o     (status_o),
    .ovr_sel_o    (ovr_sel_o),
    .ovr_code_o   (ovr_code_o)
  );

  // open drain: 0 pulls the line, 1 releases it
  assign rst_od_no = ~pulse_low;

  p_fire_all_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o) |-> (ovr_sel_o && !rst_od_no));
endmodule

// File: tb/sim_freq_wdog.sv
`timescale 1ns/1ps
module sim_freq_wdog;
  localparam int TPS = 1000;
  localparam int PW  = 288;
  localparam int SW  = 8;
  localparam int CW  = 7;

  typedef struct {
    bit             rise;
    int             at;
    logic [CW-1:0]  code;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic          tick_i;
  logic          en_i = 1'b0, reg_wr_i = 1'b0, freq_wr_i = 1'b0, status_clr_i = 1'b0;
  logic [SW-1:0] secs_i = '0;
  logic [CW-1:0] safe_code_i = '0;
  logic          rst_od_no, status_o, ovr_sel_o;
  logic [CW-1:0] ovr_code_o;

  int cyc = 0, tick_no = 0, checks = 0, errors = 0;
  bit done = 1'b0;
  item_t q[$];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tick_i) tick_no <= tick_no + 1;
  end
  assign tick_i = (cyc % 3) == 2;

  freq_wdog u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .en_i(en_i),
    .secs_i(secs_i), .safe_code_i(safe_code_i), .reg_wr_i(reg_wr_i),
    .freq_wr_i(freq_wr_i), .status_clr_i(status_clr_i),
    .rst_od_no(rst_od_no), .status_o(status_o), .ovr_sel_o(ovr_sel_o),
    .ovr_code_o(ovr_code_o)
  );

  task automatic chk(string req, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic push_exp(int fall_at, logic [CW-1:0] code);
    item_t a, b;
    a.rise = 1'b0; a.at = fall_at;      a.code = code;
    b.rise = 1'b1; b.at = fall_at + PW; b.code = code;
    q.push_back(a);
    q.push_back(b);
  endtask

  task automatic arm(int s, logic [CW-1:0] c, output int t);
    @(negedge clk);
    secs_i = SW'(s); safe_code_i = c; en_i = 1'b1;
    @(negedge clk);
    t = tick_no;
  endtask

  task automatic wait_tick(int n);
    while (tick_no < n) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic wr(bit f, bit s);
    reg_wr_i = 1'b1; freq_wr_i = f; status_clr_i = s;
    @(negedge clk);
    reg_wr_i = 1'b0; freq_wr_i = 1'b0; status_clr_i = 1'b0;
  endtask

  task automatic disable_wd();
    en_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops expected line edges and compares
  initial begin : mon
    logic  prev;
    item_t it;
    prev = 1'b1;
    @(posedge rst_ni);
    forever begin
      @(negedge clk);
      if (rst_od_no !== prev) begin
        if (q.size() == 0) begin
          chk("R10 unexpected reset edge", 1'b0, int'(rst_od_no), int'(prev));
        end else begin
          it = q.pop_front();
          chk("R4 edge kind", rst_od_no == it.rise, int'(rst_od_no), int'(it.rise));
          if (it.rise) begin
            chk("R4 release tick", tick_no == it.at, tick_no, it.at);
          end else begin
            chk("R3 timeout tick", tick_no == it.at, tick_no, it.at);
            chk("R3 status at timeout", status_o == 1'b1, int'(status_o), 1);
            chk("R2 override select", ovr_sel_o == 1'b1, int'(ovr_sel_o), 1);
            chk("R2 override code", ovr_code_o == it.code, int'(ovr_code_o), int'(it.code));
          end
        end
      end
      prev = rst_od_no;
    end
  end

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin : drv
    int t, t2;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 line released", rst_od_no == 1'b1, int'(rst_od_no), 1);
    chk("R1 status", status_o == 1'b0, int'(status_o), 0);
    chk("R1 override", ovr_sel_o == 1'b0, int'(ovr_sel_o), 0);
    chk("R1 code", ovr_code_o == '0, int'(ovr_code_o), 0);

    // R3 R2 R4 R8 R10 R9: one-second timeout and software recovery
    arm(1, 7'h2B, t);
    push_exp(t + TPS, 7'h2B);
    drain();
    wait_tick(t + 2500);
    chk("R10 halted, line released", rst_od_no == 1'b1, int'(rst_od_no), 1);
    chk("R8 status sticky", status_o == 1'b1, int'(status_o), 1);
    chk("R2 override held", ovr_code_o == 7'h2B, int'(ovr_code_o), 'h2B);
    wr(1'b1, 1'b0);
    chk("R9 freq write clears select", ovr_sel_o == 1'b0, int'(ovr_sel_o), 0);
    chk("R9 code reads zero", ovr_code_o == '0, int'(ovr_code_o), 0);
    chk("R9 status kept", status_o == 1'b1, int'(status_o), 1);
    wr(1'b0, 1'b1);
    chk("R8 status cleared", status_o == 1'b0, int'(status_o), 0);
    disable_wd();

    // R5: zero seconds acts as one
    arm(0, 7'h55, t);
    push_exp(t + TPS, 7'h55);
    drain();
    en_i = 1'b0;
    @(negedge clk);
    chk("R6 status cleared on disable", status_o == 1'b0, int'(status_o), 0);
    chk("R6 override cleared on disable", ovr_sel_o == 1'b0, int'(ovr_sel_o), 0);
    @(negedge clk);

    // R7: kick mid-count restarts
    arm(2, 7'h0F, t);
    wait_tick(t + 1500);
    wr(1'b0, 1'b0);
    t2 = tick_no;
    push_exp(t2 + 2 * TPS, 7'h0F);
    drain();
    disable_wd();

    // R7: kick on the terminal tick wins
    arm(1, 7'h33, t);
    while (!(tick_no == t + TPS - 1 && tick_i)) @(negedge clk);
    wr(1'b0, 1'b0);
    t2 = tick_no;
    chk("R7 coincident kick tick", t2 == t + TPS, t2, t + TPS);
    chk("R7 no pulse on coincident kick", rst_od_no == 1'b1, int'(rst_od_no), 1);
    chk("R7 no status on coincident kick", status_o == 1'b0, int'(status_o), 0);
    push_exp(t2 + TPS, 7'h33);
    drain();
    disable_wd();

    // R6: disable mid-count, re-enable, then disable during the pulse
    arm(1, 7'h11, t);
    wait_tick(t + 600);
    en_i = 1'b0;
    @(negedge clk);
    en_i = 1'b1;
    @(negedge clk);
    t2 = tick_no;
    push_exp(t2 + TPS, 7'h11);
    while (q.size() != 1) @(negedge clk);
    wait_tick(t2 + TPS + 100);
    en_i = 1'b0;
    @(negedge clk);
    chk("R6 status cleared mid pulse", status_o == 1'b0, int'(status_o), 0);
    chk("R6 override cleared mid pulse", ovr_sel_o == 1'b0, int'(ovr_sel_o), 0);
    chk("R6 pulse continues", rst_od_no == 1'b0, int'(rst_od_no), 0);
    drain();

    // R6: no timeout while disabled
    t = tick_no;
    wait_tick(t + 1500);
    chk("R6 idle line released", rst_od_no == 1'b1, int'(rst_od_no), 1);
    chk("R6 idle status", status_o == 1'b0, int'(status_o), 0);
    chk("R6 queue drained", q.size() == 0, q.size(), 0);
    summary();
  end
endmodule